// File: doc/BRIEF.md
# SPI Register Slave with Status-First Reply

This block is an SPI slave in mode 0 that keeps a file of sixteen 8-bit registers. It runs on a fast system clock. SCLK, chip select and MOSI come in through two-flop synchronisers, and the block finds SCLK edges by comparing each synchronised sample with the one before it. The link is full duplex, so every byte the master clocks moves one byte in each direction.

In every transaction the first byte the slave sends is its status byte. This byte goes out while the command byte is still arriving, before the slave knows what the master wants. A read command names a start register. On each byte after that, the slave returns a register, and the byte the master sends at the same time names the register for the next byte. N registers therefore take N+1 byte exchanges. A write command stores each following byte at a running address. Raising chip select ends the transaction at any point, and a byte that is not complete is never written.

Top module: `spi_regslave`

## Requirements
- R1: The first byte driven on MISO in every transaction is the value on `statusIn` while chip select was high. It goes out during the command byte.
- R2: A command byte with bit 7 = 0 is a read. Its bits 3:0 name a register, and the slave returns that register on the second byte.
- R3: During a read, bits 3:0 of each byte the master sends name the register that the slave returns on the following byte.
- R4: A command byte with bit 7 = 1 is a write. Each later byte is stored at an address that starts at bits 3:0 of the command and goes up by one after each byte, wrapping from 15 to 0. MISO carries 0x00 on the write data bytes.
- R5: With `lsbFirst` = 0, bytes move most significant bit first in both directions.
- R6: With `lsbFirst` = 1, bytes move least significant bit first in both directions.
- R7: Raising chip select part way through a byte discards that byte and writes nothing. The next transaction starts again with the status byte.
- R8: `misoOe` is 1 exactly when chip select, seen through the two-flop synchroniser, is low.
- R9: The registers do not change while chip select is high, and no clock cycle changes more than one register.
- R10: After reset all registers read 0 and `misoOe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | SPI clock from the master (mode 0) |
| csnIn | input | 1 | Active-low chip select |
| mosiIn | input | 1 | Serial data from the master |
| lsbFirst | input | 1 | 1 selects LSB-first shifting; change only while chip select is high |
| statusIn | input | 8 | Status byte sent first in each transaction |
| misoOut | output | 1 | Serial data to the master |
| misoOe | output | 1 | Output enable for MISO; MISO is undriven when this is 0 |
| regsOut | output | 128 | All registers, register i in bits 8i+7:8i |

## Verification
A new MISO bit appears three system cycles after an SCLK falling edge: two cycles in the synchroniser and one register. A register write lands three cycles after the eighth rising edge of its byte. `misoOe` follows chip select two cycles late. The bench holds each SCLK level for eight cycles and reads MISO just before it raises SCLK, at least five cycles after the last possible change. It compares registers only after chip select has gone high again. It predicts `misoOe` every cycle from its own record of the chip-select values seen at earlier clock edges.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;
  localparam int BYTE_W    = 8;
  localparam int REG_COUNT = 16;
  localparam int ADDR_W    = $clog2(REG_COUNT);
  localparam int CNT_W     = $clog2(BYTE_W);
  localparam int FLAT_W    = BYTE_W * REG_COUNT;
  localparam int CMD_BIT   = BYTE_W - 1;

  typedef enum logic [1:0] {PH_CMD, PH_READ, PH_WRITE} phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              idle;
    logic              sampleBit;
    logic              shiftTx;
    logic              loadTx;
    logic              captureRead;
    logic              clearHold;
    logic              writeReg;
    logic [ADDR_W-1:0] wrAddr;
  } strobes_t;
endpackage

// File: rtl/spi_regslave_sync.sv
module spi_regslave_sync #(
  parameter int              WIDTH     = 3,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= RESET_VAL;
        else if (s == 0) stage[s] <= asyncIn;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/spi_regslave_ctrl.sv
module spi_regslave_ctrl
  import spi_regslave_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclkS,
  input  logic              csnS,
  input  logic [BYTE_W-1:0] rxNext,
  output strobes_t          stb
);
  logic             sclkPrev;
  logic [CNT_W-1:0] bitCnt;
  phase_e           phase;
  logic [ADDR_W-1:0] addr;
  logic             pendLoad;

  logic active, rise, fall, lastBit, byteDone;

  assign active   = ~csnS;
  assign rise     = active & sclkS & ~sclkPrev;
  assign fall     = active & ~sclkS & sclkPrev;
  assign lastBit  = (bitCnt == CNT_W'(BYTE_W-1));
  assign byteDone = rise & lastBit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclkPrev <= 1'b0;
      bitCnt   <= '0;
      phase    <= PH_CMD;
      addr     <= '0;
      pendLoad <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      if (!active) begin
        bitCnt   <= '0;
        phase    <= PH_CMD;
        pendLoad <= 1'b0;
      end else begin
        if (rise) bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
        if (byteDone) begin
          pendLoad <= 1'b1;
          unique case (phase)
            PH_CMD: begin
              phase <= rxNext[CMD_BIT] ? PH_WRITE : PH_READ;
              addr  <= rxNext[ADDR_W-1:0];
            end
            PH_WRITE: addr <= (addr == ADDR_W'(REG_COUNT-1)) ? '0 : addr + 1'b1;
            default: ;
          endcase
        end else if (fall && pendLoad) begin
          pendLoad <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    stb.idle        = ~active;
    stb.sampleBit   = rise;
    stb.shiftTx     = fall & ~pendLoad;
    stb.loadTx      = fall & pendLoad;
    stb.captureRead = byteDone & ((phase == PH_CMD && !rxNext[CMD_BIT]) || phase == PH_READ);
    stb.clearHold   = byteDone & ~stb.captureRead;
    stb.writeReg    = byteDone & (phase == PH_WRITE);
    stb.wrAddr      = addr;
  end
endmodule

// File: rtl/spi_regslave_dp.sv
module spi_regslave_dp
  import spi_regslave_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mosiS,
  input  logic              lsbFirst,
  input  logic [BYTE_W-1:0] statusIn,
  input  strobes_t          stb,
  output logic [BYTE_W-1:0] rxNext,
  output logic              misoOut,
  output logic [FLAT_W-1:0] regsOut
);
  logic [BYTE_W-1:0] rxShift, txShift, txHold;
  logic [BYTE_W-1:0] regFile [REG_COUNT];
  logic [BYTE_W-1:0] rdData;

  assign rxNext  = lsbFirst ? {mosiS, rxShift[BYTE_W-1:1]} : {rxShift[BYTE_W-2:0], mosiS};
  assign rdData  = regFile[rxNext[ADDR_W-1:0]];
  assign misoOut = lsbFirst ? txShift[0] : txShift[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxShift <= '0;
      txShift <= '0;
      txHold  <= '0;
    end else begin
      if (stb.idle)           rxShift <= '0;
      else if (stb.sampleBit) rxShift <= rxNext;

      if (stb.idle)         txShift <= statusIn;
      else if (stb.loadTx)  txShift <= txHold;
      else if (stb.shiftTx) txShift <= lsbFirst ? (txShift >> 1) : (txShift << 1);

      if (stb.captureRead)    txHold <= rdData;
      else if (stb.clearHold) txHold <= '0;
    end
  end

  genvar r;
  generate
    for (r = 0; r < REG_COUNT; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regFile[r] <= '0;
        else if (stb.writeReg && stb.wrAddr == ADDR_W'(r)) regFile[r] <= rxNext;
      end
      assign regsOut[r*BYTE_W +: BYTE_W] = regFile[r];
    end
  endgenerate
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
  import spi_regslave_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclkIn,
  input  logic              csnIn,
  input  logic              mosiIn,
  input  logic              lsbFirst,
  input  logic [BYTE_W-1:0] statusIn,
  output logic              misoOut,
  output logic              misoOe,
  output logic [FLAT_W-1:0] regsOut
);
  logic     sclkS, csnS, mosiS;
  logic [BYTE_W-1:0] rxNext;
  strobes_t stb;

  spi_regslave_sync #(.WIDTH(3), .STAGES(2), .RESET_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .asyncIn({sclkIn, csnIn, mosiIn}),
    .syncOut({sclkS, csnS, mosiS})
  );

  spi_regslave_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sclkS(sclkS), .csnS(csnS),
    .rxNext(rxNext), .stb(stb)
  );

  spi_regslave_dp u_dp (
    .clk(clk), .rst_n(rst_n), .mosiS(mosiS), .lsbFirst(lsbFirst),
    .statusIn(statusIn), .stb(stb), .rxNext(rxNext),
    .misoOut(misoOut), .regsOut(regsOut)
  );

  assign misoOe = ~csnS;
endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk
  import spi_regslave_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              csnIn,
  input logic              misoOe,
  input logic [FLAT_W-1:0] regsOut
);
  logic [FLAT_W-1:0]    prevRegs;
  logic [REG_COUNT-1:0] changedMask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevRegs <= '0;
    else        prevRegs <= regsOut;
  end

  genvar r;
  generate
    for (r = 0; r < REG_COUNT; r++) begin : g_cmp
      assign changedMask[r] = regsOut[r*BYTE_W +: BYTE_W] != prevRegs[r*BYTE_W +: BYTE_W];
    end
  endgenerate

  assert_oe_needs_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    misoOe |-> !$past(csnIn, 2));

  assert_oe_off_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (csnIn && $past(csnIn)) |=> !misoOe);

  assert_regs_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (csnIn && $past(csnIn) && $past(csnIn, 2)) |=> $stable(regsOut));

  assert_single_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(changedMask));
endmodule

bind spi_regslave spi_regslave_chk u_chk (.*);

// File: tb/spi_regslave_tb.sv
module spi_regslave_tb;
  localparam int HALF = 8;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         sclkIn = 0, csnIn = 1, mosiIn = 0, lsbFirst = 0;
  logic [7:0]   statusIn = 8'h00;
  logic         misoOut, misoOe;
  logic [127:0] regsOut;

  int checks = 0, errors = 0;
  logic [7:0] mregs [16];
  logic [7:0] txBuf [8];
  logic       csnHist [$];

  spi_regslave u_dut (.*);

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // record chip select as seen at each clock edge
  always @(posedge clk) begin
    csnHist.push_back(csnIn);
    if (csnHist.size() > 4) void'(csnHist.pop_front());
  end

  // per-cycle output-enable model (R8)
  always @(negedge clk) begin
    if (rst_n && csnHist.size() >= 2)
      check(misoOe == !csnHist[csnHist.size()-2], "R8 oe", 128'(misoOe), 128'(!csnHist[csnHist.size()-2]));
  end

  function automatic logic [127:0] modelFlat();
    logic [127:0] f;
    for (int i = 0; i < 16; i++) f[i*8 +: 8] = mregs[i];
    return f;
  endfunction

  task automatic xbit(input logic b, output logic m);
    @(negedge clk) mosiIn = b;
    repeat (HALF) @(negedge clk);
    m = misoOut;
    sclkIn = 1;
    repeat (HALF) @(negedge clk);
    sclkIn = 0;
  endtask

  task automatic transact(input int n, input int abortBits);
    int ph = 0; logic [3:0] rd = 0, wa = 0;
    logic [7:0] got, exp; logic m;
    string tag;
    @(negedge clk) csnIn = 0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 8; i++) begin
        xbit(lsbFirst ? txBuf[k][i] : txBuf[k][7-i], m);
        if (lsbFirst) got[i] = m; else got[7-i] = m;
      end
      if (k == 0)       begin exp = statusIn;  tag = "R1 status"; end
      else if (ph == 1) begin exp = mregs[rd]; tag = (k == 1) ? "R2 read" : "R3 chained read"; end
      else              begin exp = 8'h00;     tag = "R4 write reply"; end
      if (lsbFirst) tag = {"R6 ", tag}; else tag = {"R5 ", tag};
      check(got == exp, tag, 128'(got), 128'(exp));
      if (k == 0) begin
        if (txBuf[k][7]) begin ph = 2; wa = txBuf[k][3:0]; end
        else begin ph = 1; rd = txBuf[k][3:0]; end
      end else if (ph == 1) rd = txBuf[k][3:0];
      else begin mregs[wa] = txBuf[k]; wa = wa + 1'b1; end
    end
    for (int i = 0; i < abortBits; i++) xbit(1'b1, m);
    repeat (HALF) @(negedge clk);
    csnIn = 1;
    repeat (2*HALF) @(negedge clk);
    check(regsOut == modelFlat(), abortBits > 0 ? "R7 abort regs" : "R4 R9 regs", regsOut, modelFlat());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mregs[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(regsOut == '0, "R10 regs reset", regsOut, '0);
    check(misoOe == 0, "R10 oe reset", 128'(misoOe), 0);

    statusIn = 8'hA5;
    txBuf[0] = 8'h03; txBuf[1] = 8'h00;
    transact(2, 0);                          // R2 on reset value

    statusIn = 8'h96;
    txBuf[0] = 8'h8E; txBuf[1] = 8'h11; txBuf[2] = 8'h22; txBuf[3] = 8'h33;
    transact(4, 0);                          // R4 wrap 15 -> 0

    txBuf[0] = 8'h81; txBuf[1] = 8'h44; txBuf[2] = 8'h55;
    transact(3, 0);

    statusIn = 8'h3C;
    txBuf[0] = 8'h0E; txBuf[1] = 8'h0F; txBuf[2] = 8'h00; txBuf[3] = 8'h01; txBuf[4] = 8'h02;
    transact(5, 0);                          // R3: five exchanges, four registers

    txBuf[0] = 8'h85;
    transact(1, 4);                          // R7 abort mid data byte
    statusIn = 8'h7E;
    txBuf[0] = 8'h05; txBuf[1] = 8'h01;
    transact(2, 0);                          // R7 fresh framing, status first

    lsbFirst = 1;
    statusIn = 8'h1D;
    txBuf[0] = 8'h83; txBuf[1] = 8'h5C; txBuf[2] = 8'hC3;
    transact(3, 0);                          // R6 write
    txBuf[0] = 8'h03; txBuf[1] = 8'h04; txBuf[2] = 8'h00;
    transact(3, 0);                          // R6 read back
    lsbFirst = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule